// File: doc/BRIEF.md
# Two-Channel Converter Register Front End

This block is the register-side front end for a two-channel analog-to-digital converter on a byte-wide peripheral register bus. Software reaches two 8-bit registers through a single address/data port. The control register holds the converter enable, a start/busy bit, a channel selector, a sticky end-of-conversion flag and a CPU-suspend request. The divider register holds a 5-bit field that sets the rate of the conversion clock enable.

The analog part of the converter lives outside. The block drives a one-cycle `conv_start` pulse on a conversion-clock tick, the latched channel number and the enable (standby) level. The converter answers with a one-cycle `conv_done` pulse and a `conv_res_ok` qualifier. A completed conversion with a valid result sets the flag, and the flag drives the interrupt request. While a conversion is in flight, a set suspend bit holds the CPU.

Top module: `adc_regfront`

## Requirements
- R1: After reset, both registers read 0x00, and `eoc_irq`, `cpu_hold`, `conv_enable` and `conv_start` are all 0.
- R2: Reserved bits always read 0, and writes to them are ignored. These are control bits 7, 2 and 1, and divider bits 7:5. Writing 0xFF to the idle control register therefore reads back 0x69, and writing 0xFF to the divider reads back 0x1F.
- R3: The divider field `d` sits in divider bits 4:0. A write to the divider restarts the conversion clock, so that `conv_tick` is high in the d-th cycle after the write and every d cycles after that. A field of 0 makes `conv_tick` high in every cycle.
- R4: The control register uses these bits: bit 6 suspend request, bit 5 enable, bit 4 end-of-conversion flag, bit 3 start/busy, bit 0 channel select. A write with bit 3 and bit 5 both 1, made while idle, starts a conversion. Bit 3 then reads 1, and `conv_start` pulses for exactly one cycle, in the first cycle at or after the write in which `conv_tick` is high.
- R5: A start write whose bit 5 is 0 is ignored. No `conv_start` follows, and bit 3 reads 0.
- R6: A start written while a conversion is in progress does not restart it. No second `conv_start` follows, and the latched channel is kept.
- R7: `conv_chan` gives the channel number latched when the start is accepted. A select bit of 1 gives channel 0, and a select bit of 0 gives channel 1.
- R8: A `conv_done` pulse during a conversion ends it. One cycle later, bit 3 reads 0. Bit 4 and `eoc_irq` go to 1 only if `conv_res_ok` was 1 with the pulse.
- R9: The flag is sticky. A write with bit 4 = 0 clears it, and a write with bit 4 = 1 leaves it unchanged. When hardware sets the flag in the same cycle that software clears it, the flag ends up set.
- R10: `cpu_hold` is high while bit 6 is 1 and a conversion is in progress. At the end of a conversion, hardware clears bit 6.
- R11: `conv_enable` follows bit 5. Writing bit 5 = 0 during a conversion abandons it: bit 3 reads 0, `cpu_hold` drops, and a later `conv_done` does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | ADDR_W | Register address |
| sfr_wr | input | 1 | Write strobe, one cycle per write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data of the addressed register (combinational) |
| conv_tick | output | 1 | Conversion clock enable, one cycle per divided period |
| conv_enable | output | 1 | Converter active (0 = standby) |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 1 | Latched channel number of the current conversion |
| conv_done | input | 1 | One-cycle end-of-conversion pulse from the converter |
| conv_res_ok | input | 1 | Result valid, qualifies `conv_done` |
| eoc_irq | output | 1 | Interrupt request, equal to the end-of-conversion flag |
| cpu_hold | output | 1 | CPU-suspend request |

## Verification
Register reads are combinational, and every write or `conv_done` is taken at one clock edge. Read values, the flag, `cpu_hold` and `conv_enable` are therefore due in the first cycle after that edge. `conv_start` is due in the first tick cycle at or after the write. The bench works out that cycle from the phase of the last divider write, so a divider of 2 can place it in either of two cycles. Each expected value goes into the scoreboard with its absolute due cycle. A monitor compares it in the cycle it is due, halfway between edges, and items due in the current cycle are compared on the spot.

// File: rtl/adc_regfront_pkg.sv
// Package: shared register layout and sequencer state for the converter
// register front end. Assumes 8-bit registers on the peripheral bus.
package adc_regfront_pkg;

    localparam int REG_W = 8;

    // Control register bit positions; software and the read mux both decode these.
    localparam int BIT_HOLD = 6;
    localparam int BIT_EN   = 5;
    localparam int BIT_EOC  = 4;
    localparam int BIT_GO   = 3;
    localparam int BIT_SEL  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_clkdiv.sv
// Module: adc_clkdiv
// Produces a one-cycle conversion clock enable every max(d,1) system cycles.
// d is the stored divide field. Assumes that a write restarts the count at
// zero, and that the new field applies from the cycle after the write.
module adc_clkdiv #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic [DIV_W-1:0] div_val,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // Terminal count: a field of 0 behaves as divide-by-1.
    always_comb begin
        limit = (div_val == '0) ? '0 : div_val - ONE;
        tick  = (cnt_q == limit);
    end

    // Holds the divide field and runs the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val <= '0;
            cnt_q   <= '0;
        end else if (div_we) begin
            div_val <= div_wdata;
            cnt_q   <= '0;
        end else if (tick) begin
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Module: adc_conv_seq
// Holds the control bits and sequences a conversion: idle -> armed (wait for
// a tick) -> converting (wait for done). Assumes write fields come in as
// separate bits and that conv_done is a one-cycle pulse.
module adc_conv_seq
    import adc_regfront_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic wr_hold,
    input  logic wr_en,
    input  logic wr_eoc,
    input  logic wr_go,
    input  logic wr_sel,
    input  logic tick,
    input  logic done,
    input  logic res_ok,
    output logic hold_bit,
    output logic en_bit,
    output logic eoc_bit,
    output logic sel_bit,
    output logic busy,
    output logic converting,
    output logic start_pulse,
    output logic chan,
    output logic cpu_hold
);

    seq_state_t state_q, state_n;
    logic       accept, abort, finish;

    // Decode the events of this cycle.
    always_comb begin
        accept      = ctrl_we && wr_go && wr_en && (state_q == ST_IDLE);
        abort       = ctrl_we && !wr_en && (state_q != ST_IDLE);
        finish      = (state_q == ST_CONV) && done;
        start_pulse = (state_q == ST_ARM) && tick;
        busy        = (state_q != ST_IDLE);
        converting  = (state_q == ST_CONV);
        cpu_hold    = hold_bit && busy;
    end

    // Next state of the sequencer.
    always_comb begin
        state_n = state_q;
        if (abort) begin
            state_n = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_n = ST_ARM;
                ST_ARM:  if (tick)   state_n = ST_CONV;
                ST_CONV: if (done)   state_n = ST_IDLE;
                default:             state_n = ST_IDLE;
            endcase
        end
    end

    // State register and software-written control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_bit  <= 1'b0;
            sel_bit <= 1'b0;
        end else begin
            state_q <= state_n;
            if (ctrl_we) begin
                en_bit  <= wr_en;
                sel_bit <= wr_sel;
            end
        end
    end

    // Suspend request: the end of a conversion clears it ahead of any write.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_bit <= 1'b0;
        else if (finish)  hold_bit <= 1'b0;
        else if (ctrl_we) hold_bit <= wr_hold;
    end

    // Sticky flag: a hardware set beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  eoc_bit <= 1'b0;
        else if (finish && res_ok)   eoc_bit <= 1'b1;
        else if (ctrl_we && !wr_eoc) eoc_bit <= 1'b0;
    end

    // Latches the channel number when a start is accepted (select 1 -> channel 0).
    always_ff @(posedge clk) begin
        if (!rst_n)      chan <= 1'b0;
        else if (accept) chan <= !wr_sel;
    end

endmodule

// File: rtl/adc_sfr_rdmux.sv
// Module: adc_sfr_rdmux
// Combinational read-back of both registers, with reserved bits forced to 0.
// Assumes that an unmatched address reads 0.
module adc_sfr_rdmux
    import adc_regfront_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DIV_W     = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA0,
    parameter logic [ADDR_W-1:0] DIV_ADDR  = 8'hA1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hold_bit,
    input  logic              en_bit,
    input  logic              eoc_bit,
    input  logic              busy,
    input  logic              sel_bit,
    input  logic [DIV_W-1:0]  div_val,
    output logic [REG_W-1:0]  rdata
);

    // Selects and assembles the addressed register image.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[BIT_HOLD] = hold_bit;
            rdata[BIT_EN]   = en_bit;
            rdata[BIT_EOC]  = eoc_bit;
            rdata[BIT_GO]   = busy;
            rdata[BIT_SEL]  = sel_bit;
        end else if (addr == DIV_ADDR) begin
            rdata[DIV_W-1:0] = div_val;
        end
    end

endmodule

// File: rtl/adc_regfront.sv
// Module: adc_regfront (top)
// Register front end for a two-channel converter: address decode, the
// conversion clock divider, the control sequencer and the read mux. Assumes a
// single-cycle write strobe and reads that are combinational on the address.
module adc_regfront
    import adc_regfront_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DIV_W     = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA0,
    parameter logic [ADDR_W-1:0] DIV_ADDR  = 8'hA1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    output logic              conv_tick,
    output logic              conv_enable,
    output logic              conv_start,
    output logic              conv_chan,
    input  logic              conv_done,
    input  logic              conv_res_ok,
    output logic              eoc_irq,
    output logic              cpu_hold
);

    logic             ctrl_we, div_we;
    logic             hold_bit, en_bit, eoc_bit, sel_bit;
    logic             busy, converting;
    logic [DIV_W-1:0] div_val;
    logic             wdata_unused;

    // Address decode of the write strobe.
    always_comb begin
        ctrl_we = sfr_wr && (sfr_addr == CTRL_ADDR);
        div_we  = sfr_wr && (sfr_addr == DIV_ADDR);
    end

    assign wdata_unused = sfr_wdata[REG_W-1];
    assign conv_enable  = en_bit;
    assign eoc_irq      = eoc_bit;

    adc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_we    (div_we),
        .div_wdata (sfr_wdata[DIV_W-1:0]),
        .div_val   (div_val),
        .tick      (conv_tick)
    );

    adc_conv_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .wr_hold     (sfr_wdata[BIT_HOLD]),
        .wr_en       (sfr_wdata[BIT_EN]),
        .wr_eoc      (sfr_wdata[BIT_EOC]),
        .wr_go       (sfr_wdata[BIT_GO]),
        .wr_sel      (sfr_wdata[BIT_SEL]),
        .tick        (conv_tick),
        .done        (conv_done),
        .res_ok      (conv_res_ok),
        .hold_bit    (hold_bit),
        .en_bit      (en_bit),
        .eoc_bit     (eoc_bit),
        .sel_bit     (sel_bit),
        .busy        (busy),
        .converting  (converting),
        .start_pulse (conv_start),
        .chan        (conv_chan),
        .cpu_hold    (cpu_hold)
    );

    adc_sfr_rdmux #(
        .ADDR_W    (ADDR_W),
        .DIV_W     (DIV_W),
        .CTRL_ADDR (CTRL_ADDR),
        .DIV_ADDR  (DIV_ADDR)
    ) u_rd (
        .addr     (sfr_addr),
        .hold_bit (hold_bit),
        .en_bit   (en_bit),
        .eoc_bit  (eoc_bit),
        .busy     (busy),
        .sel_bit  (sel_bit),
        .div_val  (div_val),
        .rdata    (sfr_rdata)
    );

endmodule

// File: rtl/adc_regfront_chk.sv
// Module: adc_regfront_chk
// Temporal checks on the front end, bound to every adc_regfront instance.
module adc_regfront_chk (
    input logic clk,
    input logic rst_n,
    input logic ctrl_we,
    input logic wr_eoc,
    input logic conv_tick,
    input logic conv_enable,
    input logic conv_start,
    input logic conv_done,
    input logic eoc_irq,
    input logic cpu_hold,
    input logic busy,
    input logic converting
);

    // R4: a start pulse only ever lands on a conversion tick
    a_r4_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_tick);

    // R4: a start pulse lasts exactly one cycle
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R11: no start is issued in standby
    a_r11_no_start_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_enable |-> !conv_start);

    // R9: the flag stays set unless software writes bit 4 as 0
    a_r9_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_irq && !(ctrl_we && !wr_eoc)) |=> eoc_irq);

    // R10: the suspend request is only raised during a conversion
    a_r10_hold_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |-> busy);

    // R8: done during a conversion returns the sequencer to idle
    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (converting && conv_done) |=> !busy);

endmodule

bind adc_regfront adc_regfront_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .wr_eoc      (sfr_wdata[4]),
    .conv_tick   (conv_tick),
    .conv_enable (conv_enable),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .eoc_irq     (eoc_irq),
    .cpu_hold    (cpu_hold),
    .busy        (busy),
    .converting  (converting)
);

// File: tb/adc_regfront_test.sv
`timescale 1ns/1ps
module adc_regfront_test;

    localparam logic [7:0] CA = 8'hA0;
    localparam logic [7:0] DA = 8'hA1;
    localparam int S_IRQ = 0, S_HOLD = 1, S_START = 2, S_CHAN = 3, S_EN = 4, S_TICK = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = '0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic       conv_tick, conv_enable, conv_start, conv_chan;
    logic       conv_done = 1'b0;
    logic       conv_res_ok = 1'b0;
    logic       eoc_irq, cpu_hold;

    always #2.5 clk = ~clk;

    adc_regfront uut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .conv_tick(conv_tick),
        .conv_enable(conv_enable), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_res_ok(conv_res_ok), .eoc_irq(eoc_irq),
        .cpu_hold(cpu_hold)
    );

    typedef struct {
        int    due;
        int    sig;
        int    val;
        string req;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    ended = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int probe(int s);
        case (s)
            S_IRQ:   return int'(eoc_irq);
            S_HOLD:  return int'(cpu_hold);
            S_START: return int'(conv_start);
            S_CHAN:  return int'(conv_chan);
            S_EN:    return int'(conv_enable);
            default: return int'(conv_tick);
        endcase
    endfunction

    function automatic void cmp(int s, int v, string req);
        n_chk++;
        if (probe(s) !== v) begin
            n_err++;
            $display("FAIL %s cycle %0d signal %0d: actual %0d expected %0d",
                     req, cyc, s, probe(s), v);
        end
    endfunction

    // Driver side: queue an expectation due `delay` cycles from now.
    function automatic void expect_at(int s, int v, int delay, string req);
        item_t it;
        if (delay <= 0) begin
            cmp(s, v, req);
        end else begin
            it.due = cyc + delay; it.sig = s; it.val = v; it.req = req;
            sbq.push_back(it);
        end
    endfunction

    // Monitor: compare every item that is due in this cycle.
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                cmp(sbq[i].sig, sbq[i].val, sbq[i].req);
                sbq.delete(i);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk); #1;
        sfr_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        sfr_addr = a; #0.2;
        n_chk++;
        if (sfr_rdata !== exp) begin
            n_err++;
            $display("FAIL %s read %02h: actual %02h expected %02h", req, a, sfr_rdata, exp);
        end
    endtask

    task automatic done_pulse(input logic ok, input bit with_clear);
        @(negedge clk); #1;
        conv_done = 1'b1; conv_res_ok = ok;
        if (with_clear) begin
            sfr_addr = CA; sfr_wdata = 8'h20; sfr_wr = 1'b1;
        end
        @(negedge clk); #1;
        conv_done = 1'b0; conv_res_ok = 1'b0; sfr_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ld, lc, t;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        rd_chk(CA, 8'h00, "R1");
        rd_chk(DA, 8'h00, "R1");
        expect_at(S_IRQ, 0, 0, "R1");
        expect_at(S_HOLD, 0, 0, "R1");
        expect_at(S_EN, 0, 0, "R1");
        expect_at(S_START, 0, 0, "R1");

        // R2: reserved divider bits
        wr(DA, 8'hFF);
        rd_chk(DA, 8'h1F, "R2");

        // R3: divide by 3, restart on write, then divide by 1
        wr(DA, 8'h03);
        for (int k = 1; k <= 7; k++) expect_at(S_TICK, (k % 3 == 0) ? 1 : 0, k - 1, "R3");
        wait_cyc(8);
        wr(DA, 8'h04);
        for (int k = 1; k <= 9; k++) expect_at(S_TICK, (k % 4 == 0) ? 1 : 0, k - 1, "R3");
        wait_cyc(10);
        wr(DA, 8'h00);
        for (int k = 1; k <= 3; k++) expect_at(S_TICK, 1, k - 1, "R3");
        wait_cyc(3);

        // R5: start with enable 0 is ignored
        wr(CA, 8'h08);
        rd_chk(CA, 8'h00, "R5");
        for (int k = 0; k < 3; k++) expect_at(S_START, 0, k, "R5");
        wait_cyc(4);

        // R4, R7: divide by 2, start on the first tick, channel select 1 -> channel 0
        wr(DA, 8'h02);
        ld = cyc;
        wait_cyc(1);
        wr(CA, 8'h29);
        lc = cyc;
        t = lc;
        while (((t - ld + 1) % 2) != 0) t++;
        for (int c = lc; c <= t + 2; c++) expect_at(S_START, (c == t) ? 1 : 0, c - lc, "R4");
        expect_at(S_EN, 1, 0, "R11");
        rd_chk(CA, 8'h29, "R4");
        wait_cyc(t + 3 - lc);
        expect_at(S_CHAN, 0, 0, "R7");

        // R6: start again while converting, with select 0 -> no restart, channel kept
        wr(CA, 8'h28);
        for (int k = 0; k < 4; k++) expect_at(S_START, 0, k, "R6");
        expect_at(S_CHAN, 0, 3, "R6");
        wait_cyc(4);

        // R8: done with a valid result
        done_pulse(1'b1, 1'b0);
        expect_at(S_IRQ, 1, 0, "R8");
        rd_chk(CA, 8'h30, "R8");

        // R9: writing 1 keeps the flag, writing 0 clears it
        wr(CA, 8'h30);
        expect_at(S_IRQ, 1, 0, "R9");
        wr(CA, 8'h20);
        expect_at(S_IRQ, 0, 0, "R9");

        // R9: a hardware set wins over a software clear in the same cycle
        wr(DA, 8'h00);
        wr(CA, 8'h28);
        wait_cyc(2);
        done_pulse(1'b1, 1'b1);
        expect_at(S_IRQ, 1, 0, "R9");
        wr(CA, 8'h20);

        // R8: done with no valid result leaves the flag clear; select 0 -> channel 1
        wr(CA, 8'h28);
        wait_cyc(2);
        expect_at(S_CHAN, 1, 0, "R7");
        done_pulse(1'b0, 1'b0);
        expect_at(S_IRQ, 0, 0, "R8");
        rd_chk(CA, 8'h20, "R8");

        // R10: suspend request during a conversion, cleared at the end
        wr(CA, 8'h68);
        expect_at(S_HOLD, 1, 0, "R10");
        wait_cyc(2);
        expect_at(S_HOLD, 1, 0, "R10");
        done_pulse(1'b1, 1'b0);
        expect_at(S_HOLD, 0, 0, "R10");
        rd_chk(CA, 8'h30, "R10");
        wr(CA, 8'h20);

        // R11: clearing the enable abandons the conversion
        wr(CA, 8'h68);
        wait_cyc(2);
        wr(CA, 8'h40);
        expect_at(S_EN, 0, 0, "R11");
        expect_at(S_HOLD, 0, 0, "R11");
        rd_chk(CA, 8'h40, "R11");
        done_pulse(1'b1, 1'b0);
        expect_at(S_IRQ, 0, 0, "R11");

        // R2: reserved control bits read 0 on a full write
        wr(CA, 8'hFF);
        rd_chk(CA, 8'h69, "R2");

        wait_cyc(3);
        if (sbq.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        finish_run();
    end

endmodule